// File: doc/BRIEF.md
# Parallel 8-Bit Display Bus Master

This block turns requests on a valid/ready command port into strobed byte transfers on an 8-bit parallel display bus. The bus has a chip select, a command/data select, separate write and read strobes, a display reset line, and a data byte whose output driver can be switched off for reads. The command port carries an operation code, a 16-bit data word, an 8-bit address and a pixel count. Read results come back on a response port as a one-cycle pulse with a 32-bit word.

The controller orders the bytes of every transfer, turns the bus around for reads, and discards the leading dummy byte the panel returns. It repacks three 6-bit colour bytes read back from pixel memory into a 5-6-5 word. It ends a 32-bit register read with a short chip-select pulse, and it runs the timed display reset sequence on its own after a system reset. Strobe phase lengths are set in system clocks. The reset delays are derived from a clock-frequency parameter, and a divider parameter lets a testbench shorten them.

Top module: `par8_bus_master`

## Requirements
- R1: While system reset is asserted and afterwards, the write strobe, the read strobe, the command select and the chip select all idle high, and the data driver is enabled. `cmd_ready` stays low until the automatic display reset sequence has finished.
- R2: A request is taken when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while no operation is running. The `cmd_op` codes are: 0 command byte, 1 data byte, 2 pixel write, 3 fill, 4 pixel read, 5 32-bit register read, 6 indexed register write, 7 indexed register read, 8 display reset.
- R3: Code 0 strobes `cmd_data[7:0]` with `disp_cmd_n` low, and `disp_cmd_n` is high again once that byte is complete. Code 1 strobes the same byte with `disp_cmd_n` high. Each byte gives exactly one low pulse of `disp_wr_n`, and `disp_dout` is stable while the pulse is low.
- R4: Every 16-bit value goes out high byte first: the pixel write (code 2) and the two data bytes of the indexed write (code 6).
- R5: A fill (code 3) with count N produces 2N write strobes that alternate between `cmd_data[15:8]` and `cmd_data[7:0]`. When the two halves are equal, this is 2N strobes of that one byte. A count of zero produces no strobes.
- R6: A pixel read (code 4) gives four read strobes, and the first byte is thrown away. The next three bytes b1, b2 and b3 return as `rsp_data = {16'h0, b1[7:3], b2[7:2], b3[7:3]}`, with `rsp_valid` high for one cycle.
- R7: A 32-bit register read (code 5) strobes `cmd_addr` as a command byte, then gives five read strobes. The first byte is thrown away, and the remaining four return in arrival order, most significant byte first, in `rsp_data`.
- R8: After the last byte of a code-5 read, `disp_cs_n` is high for exactly one cycle. After that it follows the enable input again.
- R9: An indexed access (codes 6 and 7) strobes 8'h00 and then `cmd_addr`, both with `disp_cmd_n` low. A read then gives exactly two read strobes, with no dummy byte, and returns `{16'h0, first, second}`.
- R10: The display reset sequence (code 8, and automatically after system reset) first waits 15 ms with every control line high, including the chip select. It then holds `disp_rst_n` low for exactly 2 ms and waits exactly 100 ms before `cmd_ready` rises.
- R11: Outside the reset sequence and the R8 pulse, `disp_cs_n` is the inverse of `bus_en`, one register later.
- R12: `disp_doe` is low for at least one cycle before `disp_rd_n` falls. It is never high while `disp_rd_n` is low, and it rises only after `disp_rd_n` has been high for a cycle.
- R13: The two strobes are never low together. A read byte is sampled on the last low cycle of `disp_rd_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_en | input | 1 | Bus enable request, drives chip select low |
| cmd_valid | input | 1 | Request valid |
| cmd_ready | output | 1 | Controller idle, request can be taken |
| cmd_op | input | 4 | Operation code |
| cmd_data | input | 16 | Byte, pixel or register data |
| cmd_addr | input | 8 | Register number or index |
| cmd_count | input | CNT_W | Fill pixel count |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_data | output | 32 | Read result |
| disp_cs_n | output | 1 | Chip select, active low |
| disp_cmd_n | output | 1 | Low while a command byte is transferred |
| disp_wr_n | output | 1 | Write strobe, active low |
| disp_rd_n | output | 1 | Read strobe, active low |
| disp_rst_n | output | 1 | Display reset, active low |
| disp_dout | output | 8 | Outgoing data byte |
| disp_doe | output | 1 | Data output driver enable |
| disp_din | input | 8 | Incoming data byte |

## Verification
The chip select is the one line that two functions contend for in the same cycle. The enable request wants it low, while the end-of-register-read pulse and the reset sequence want it high. The bench keeps `bus_en` asserted through register reads and resets, so every cycle in which chip select goes high must come from the pulse or the reset. It counts the high cycles, expecting exactly one per register read and none for the other operations, and it flags any cycle in which reset is low while chip select is low.

// File: rtl/par8_pkg.sv
package par8_pkg;

  typedef enum logic [3:0] {
    OP_CMD   = 4'd0,
    OP_DATA  = 4'd1,
    OP_PIX   = 4'd2,
    OP_FILL  = 4'd3,
    OP_RDPIX = 4'd4,
    OP_RDREG = 4'd5,
    OP_IDXWR = 4'd6,
    OP_IDXRD = 4'd7,
    OP_RESET = 4'd8
  } op_e;

  typedef enum logic [2:0] {K_WR, K_RD, K_TURN, K_BLIP, K_DLY, K_NOP} kind_e;

  typedef enum logic [1:0] {E_IDLE, E_LOW, E_HIGH} eph_e;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_e;

  typedef struct packed {
    kind_e      kind;
    logic       cmd;
    logic       drop;
    logic [7:0] val;
    logic       last;
    logic [1:0] dly;
  } step_t;

  // Step table: what bus action step idx of an operation performs.
  function automatic step_t step_of(op_e op, logic [2:0] idx, logic [15:0] data,
                                    logic [7:0] addr, logic fill_odd, logic fill_one);
    step_t s;
    s.kind = K_WR;
    s.cmd  = 1'b0;
    s.drop = 1'b0;
    s.val  = 8'h00;
    s.last = 1'b1;
    s.dly  = 2'd0;
    case (op)
      OP_CMD:  begin s.cmd = 1'b1; s.val = data[7:0]; end
      OP_DATA: s.val = data[7:0];
      OP_PIX:  begin s.val = idx[0] ? data[7:0] : data[15:8]; s.last = idx[0]; end
      OP_FILL: begin s.val = fill_odd ? data[7:0] : data[15:8]; s.last = fill_one; end
      OP_RDPIX: begin
        s.kind = (idx == 3'd0) ? K_TURN : K_RD;
        s.drop = (idx == 3'd1);
        s.last = (idx == 3'd4);
      end
      OP_RDREG: begin
        s.kind = (idx == 3'd0) ? K_WR : (idx == 3'd1) ? K_TURN :
                 (idx == 3'd7) ? K_BLIP : K_RD;
        s.cmd  = (idx == 3'd0);
        s.val  = addr;
        s.drop = (idx == 3'd2);
        s.last = (idx == 3'd7);
      end
      OP_IDXWR: begin
        s.cmd  = (idx < 3'd2);
        s.val  = (idx == 3'd0) ? 8'h00 : (idx == 3'd1) ? addr :
                 (idx == 3'd2) ? data[15:8] : data[7:0];
        s.last = (idx == 3'd3);
      end
      OP_IDXRD: begin
        s.kind = (idx < 3'd2) ? K_WR : (idx == 3'd2) ? K_TURN : K_RD;
        s.cmd  = (idx < 3'd2);
        s.val  = (idx == 3'd0) ? 8'h00 : addr;
        s.last = (idx == 3'd4);
      end
      OP_RESET: begin s.kind = K_DLY; s.dly = idx[1:0]; s.last = (idx == 3'd2); end
      default: s.kind = K_NOP;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/par8_strobe.sv
module par8_strobe
  import par8_pkg::*;
#(
  parameter int LOW_CYC  = 2,
  parameter int HIGH_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       go_rd,
  input  logic       go_cmd,
  input  logic [7:0] go_val,
  output logic       done,
  output logic       smp,
  output logic       wr_n,
  output logic       rd_n,
  output logic       cmd_n,
  output logic [7:0] d_out
);
  localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] LOW_END  = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HIGH_END = CW'(HIGH_CYC - 1);

  eph_e          ph, ph_d;
  logic [CW-1:0] cnt, cnt_d;
  logic          rd_q, rd_d, cmd_q, cmd_d;
  logic [7:0]    val_q, val_d;

  always_comb begin
    ph_d  = ph;
    cnt_d = cnt;
    rd_d  = rd_q;
    cmd_d = cmd_q;
    val_d = val_q;
    done  = 1'b0;
    smp   = 1'b0;
    case (ph)
      E_IDLE: if (go) begin
        ph_d  = E_LOW;
        cnt_d = '0;
        rd_d  = go_rd;
        cmd_d = go_cmd;
        if (!go_rd) val_d = go_val;
      end
      E_LOW: if (cnt == LOW_END) begin
        smp   = rd_q;
        ph_d  = E_HIGH;
        cnt_d = '0;
      end else cnt_d = cnt + 1'b1;
      E_HIGH: if (cnt == HIGH_END) begin
        done = 1'b1;
        ph_d = E_IDLE;
      end else cnt_d = cnt + 1'b1;
      default: ph_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= E_IDLE;
      cnt   <= '0;
      rd_q  <= 1'b0;
      cmd_q <= 1'b0;
      val_q <= 8'h00;
    end else begin
      ph    <= ph_d;
      cnt   <= cnt_d;
      rd_q  <= rd_d;
      cmd_q <= cmd_d;
      val_q <= val_d;
    end
  end

  assign wr_n  = !(ph == E_LOW && !rd_q);
  assign rd_n  = !(ph == E_LOW && rd_q);
  assign cmd_n = !(ph != E_IDLE && cmd_q);
  assign d_out = val_q;
endmodule

// File: rtl/par8_delay.sv
module par8_delay #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt, cnt_d;

  always_comb begin
    if (load)            cnt_d = val;
    else if (cnt != '0)  cnt_d = cnt - 1'b1;
    else                 cnt_d = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assign done = (cnt == W'(1));
endmodule

// File: rtl/par8_pix_pack.sv
module par8_pix_pack (
  input  logic [23:0] rgb666,
  output logic [15:0] rgb565
);
  // Each colour byte is 6 bits left-aligned; keep the top 5/6/5 bits.
  assign rgb565 = {rgb666[23:19], rgb666[15:10], rgb666[7:3]};
endmodule

// File: rtl/par8_bus_master.sv
module par8_bus_master
  import par8_pkg::*;
#(
  parameter int CLK_HZ   = 125_000_000,
  parameter int TIME_DIV = 1,
  parameter int LOW_CYC  = 2,
  parameter int HIGH_CYC = 2,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [3:0]       cmd_op,
  input  logic [15:0]      cmd_data,
  input  logic [7:0]       cmd_addr,
  input  logic [CNT_W-1:0] cmd_count,
  output logic             rsp_valid,
  output logic [31:0]      rsp_data,
  output logic             disp_cs_n,
  output logic             disp_cmd_n,
  output logic             disp_wr_n,
  output logic             disp_rd_n,
  output logic             disp_rst_n,
  output logic [7:0]       disp_dout,
  output logic             disp_doe,
  input  logic [7:0]       disp_din
);
  localparam int MS_RAW   = CLK_HZ / 1000 / TIME_DIV;
  localparam int MS_CYC   = (MS_RAW < 1) ? 1 : MS_RAW;
  localparam int PRE_CYC  = 15 * MS_CYC;
  localparam int HOLD_CYC = 2 * MS_CYC;
  localparam int POST_CYC = 100 * MS_CYC;
  localparam int DW       = $clog2(POST_CYC + 1);

  seq_e             st, st_d;
  op_e              op_q, op_d;
  logic [15:0]      data_q, data_d;
  logic [7:0]       addr_q, addr_d;
  logic [2:0]       idx_q, idx_d;
  logic [CNT_W:0]   left_q, left_d;
  logic [31:0]      shift_q, shift_d, rsp_q, rsp_d;
  logic             oe_q, oe_d, cs_q, cs_d, rst_q, rst_d, rv_q, rv_d;
  logic             finish, eng_go, eng_done, eng_smp, dly_load, dly_done;
  logic [DW-1:0]    dly_val;
  logic [15:0]      packed565;
  step_t            stp;

  assign stp = step_of(op_q, idx_q, data_q, addr_q, left_q[0], left_q == (CNT_W+1)'(1));

  par8_pix_pack u_pack (.rgb666(shift_q[23:0]), .rgb565(packed565));

  par8_strobe #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_strobe (
    .clk(clk), .rst_n(rst_n), .go(eng_go), .go_rd(stp.kind == K_RD), .go_cmd(stp.cmd),
    .go_val(stp.val), .done(eng_done), .smp(eng_smp), .wr_n(disp_wr_n), .rd_n(disp_rd_n),
    .cmd_n(disp_cmd_n), .d_out(disp_dout));

  par8_delay #(.W(DW)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .val(dly_val), .done(dly_done));

  always_comb begin
    case (stp.dly)
      2'd0:    dly_val = DW'(PRE_CYC);
      2'd1:    dly_val = DW'(HOLD_CYC);
      default: dly_val = DW'(POST_CYC);
    endcase
  end

  always_comb begin
    st_d = st; op_d = op_q; data_d = data_q; addr_d = addr_q; idx_d = idx_q;
    left_d = left_q; shift_d = shift_q; rsp_d = rsp_q; oe_d = oe_q; rv_d = 1'b0;
    finish = 1'b0; eng_go = 1'b0; dly_load = 1'b0;
    case (st)
      S_IDLE: if (cmd_valid) begin
        op_d    = op_e'(cmd_op);
        data_d  = cmd_data;
        addr_d  = cmd_addr;
        idx_d   = 3'd0;
        left_d  = {cmd_count, 1'b0};
        shift_d = '0;
        st_d    = S_ISSUE;
      end
      S_ISSUE: begin
        if (op_q == OP_FILL && left_q == '0) finish = 1'b1;
        else begin
          case (stp.kind)
            K_WR, K_RD: begin eng_go = 1'b1; st_d = S_WAIT; end
            K_DLY:      begin dly_load = 1'b1; st_d = S_WAIT; end
            K_TURN, K_BLIP: begin
              if (stp.kind == K_TURN) oe_d = 1'b0;
              if (stp.last) finish = 1'b1;
              else idx_d = idx_q + 3'd1;
            end
            default: finish = 1'b1;
          endcase
        end
      end
      S_WAIT: begin
        if (eng_smp && !stp.drop) shift_d = {shift_q[23:0], disp_din};
        if (eng_done || dly_done) begin
          if (stp.last) finish = 1'b1;
          else begin
            idx_d  = idx_q + 3'd1;
            left_d = left_q - 1'b1;
            st_d   = S_ISSUE;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (finish) begin
      st_d = S_IDLE;
      oe_d = 1'b1;
      case (op_q)
        OP_RDPIX: begin rv_d = 1'b1; rsp_d = {16'h0, packed565}; end
        OP_RDREG: begin rv_d = 1'b1; rsp_d = shift_q; end
        OP_IDXRD: begin rv_d = 1'b1; rsp_d = {16'h0, shift_q[15:0]}; end
        default: ;
      endcase
    end
    cs_d  = ((op_q == OP_RESET) && (st != S_IDLE)) ||
            ((st == S_ISSUE) && (stp.kind == K_BLIP)) ? 1'b1 : !bus_en;
    rst_d = !((op_q == OP_RESET) && (st == S_WAIT) && (idx_q == 3'd1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_ISSUE; op_q <= OP_RESET; data_q <= '0; addr_q <= '0; idx_q <= '0;
      left_q <= '0; shift_q <= '0; rsp_q <= '0; oe_q <= 1'b1; cs_q <= 1'b1;
      rst_q <= 1'b1; rv_q <= 1'b0;
    end else begin
      st <= st_d; op_q <= op_d; data_q <= data_d; addr_q <= addr_d; idx_q <= idx_d;
      left_q <= left_d; shift_q <= shift_d; rsp_q <= rsp_d; oe_q <= oe_d; cs_q <= cs_d;
      rst_q <= rst_d; rv_q <= rv_d;
    end
  end

  assign cmd_ready  = (st == S_IDLE);
  assign rsp_valid  = rv_q;
  assign rsp_data   = rsp_q;
  assign disp_cs_n  = cs_q;
  assign disp_rst_n = rst_q;
  assign disp_doe   = oe_q;
endmodule

// File: rtl/par8_bus_master_chk.sv
module par8_bus_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_ready,
  input logic       rsp_valid,
  input logic       disp_cs_n,
  input logic       disp_wr_n,
  input logic       disp_rd_n,
  input logic       disp_rst_n,
  input logic [7:0] disp_dout,
  input logic       disp_doe
);
  assert_one_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(!disp_wr_n && !disp_rd_n));
  assert_read_undriven_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_rd_n |-> !disp_doe);
  assert_turn_early_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(disp_rd_n) |-> !$past(disp_doe));
  assert_turn_back_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_doe) |-> (disp_rd_n && $past(disp_rd_n)));
  assert_write_driven_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_wr_n |-> disp_doe);
  assert_byte_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_wr_n && !$past(disp_wr_n)) |-> $stable(disp_dout));
  assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_rst_n |-> (!cmd_ready && disp_cs_n && disp_wr_n && disp_rd_n));
  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind par8_bus_master par8_bus_master_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
  .disp_cs_n(disp_cs_n), .disp_wr_n(disp_wr_n), .disp_rd_n(disp_rd_n),
  .disp_rst_n(disp_rst_n), .disp_dout(disp_dout), .disp_doe(disp_doe));

// File: tb/test_par8_bus_master.sv
module test_par8_bus_master;
  localparam int DIV  = 1000;
  localparam int MS   = 125_000_000 / 1000 / DIV;
  localparam int PRE  = 15 * MS;
  localparam int HOLD = 2 * MS;
  localparam int POST = 100 * MS;

  logic clk = 1'b0, rst_n = 1'b0, bus_en = 1'b1, cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [15:0] cmd_data = '0, cmd_count = '0;
  logic [7:0] cmd_addr = '0, disp_din = '0;
  logic cmd_ready, rsp_valid, disp_cs_n, disp_cmd_n, disp_wr_n, disp_rd_n, disp_rst_n, disp_doe;
  logic [31:0] rsp_data;
  logic [7:0] disp_dout;

  par8_bus_master #(.TIME_DIV(DIV)) i_par8_bus_master (.*);

  always #4 clk = ~clk;

  int vectors = 0, fails = 0, cycles = 0;
  int wn, rn, rspn, cs_hi, oe_bad, both_low, rlow, rpre, rpost, cs_bad;
  logic [7:0] wl_val [0:63];
  logic       wl_cmd [0:63];
  logic [7:0] feed [0:7];
  logic [31:0] rsp_got;
  logic prev_wr = 1'b1, prev_rd = 1'b1;

  logic [7:0] ex_val [0:63];
  logic       ex_cmd [0:63];
  int ex_n, ex_rd, ex_cs;
  logic ex_has;
  logic [31:0] ex_rsp;

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (prev_wr === 1'b1 && disp_wr_n === 1'b0 && wn < 64) begin
      wl_val[wn] = disp_dout; wl_cmd[wn] = !disp_cmd_n; wn++;
    end
    if (prev_rd === 1'b1 && disp_rd_n === 1'b0) begin
      disp_din = feed[rn % 8]; rn++;
    end
    prev_wr = disp_wr_n; prev_rd = disp_rd_n;
    if (rsp_valid === 1'b1) begin rsp_got = rsp_data; rspn++; end
    if (disp_cs_n === 1'b1) cs_hi++;
    if (disp_rd_n === 1'b0 && disp_doe !== 1'b0) oe_bad++;
    if (disp_rd_n === 1'b0 && disp_wr_n === 1'b0) both_low++;
    if (disp_rst_n === 1'b0) begin rlow++; if (disp_cs_n !== 1'b1) cs_bad++; end
    else if (cmd_ready === 1'b0 && rlow > 0) rpost++;
    else if (cmd_ready === 1'b0) rpre++;
    if (cycles > 150000) begin
      fails++; $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      summary();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear;
    wn = 0; rn = 0; rspn = 0; cs_hi = 0; oe_bad = 0; both_low = 0;
    rlow = 0; rpre = 0; rpost = 0; cs_bad = 0;
  endtask

  function automatic logic [15:0] pack565(logic [7:0] r, logic [7:0] g, logic [7:0] b);
    return {r[7:3], g[7:2], b[7:3]};
  endfunction

  task automatic push(logic c, logic [7:0] v);
    ex_cmd[ex_n] = c; ex_val[ex_n] = v; ex_n++;
  endtask

  task automatic build(int op, logic [15:0] d, logic [7:0] a, int n);
    ex_n = 0; ex_rd = 0; ex_cs = 0; ex_has = 1'b0; ex_rsp = '0;
    case (op)
      0: push(1'b1, d[7:0]);
      1: push(1'b0, d[7:0]);
      2: begin push(1'b0, d[15:8]); push(1'b0, d[7:0]); end
      3: for (int i = 0; i < n; i++) begin push(1'b0, d[15:8]); push(1'b0, d[7:0]); end
      4: begin ex_rd = 4; ex_has = 1'b1; ex_rsp = {16'h0, pack565(feed[1], feed[2], feed[3])}; end
      5: begin push(1'b1, a); ex_rd = 5; ex_cs = 1; ex_has = 1'b1;
               ex_rsp = {feed[1], feed[2], feed[3], feed[4]}; end
      6: begin push(1'b1, 8'h00); push(1'b1, a); push(1'b0, d[15:8]); push(1'b0, d[7:0]); end
      7: begin push(1'b1, 8'h00); push(1'b1, a); ex_rd = 2; ex_has = 1'b1;
               ex_rsp = {16'h0, feed[0], feed[1]}; end
      default: ;
    endcase
  endtask

  task automatic run_op(int op, logic [15:0] d, logic [7:0] a, int n);
    @(negedge clk); #1;
    clear();
    cmd_valid = 1'b1; cmd_op = 4'(op); cmd_data = d; cmd_addr = a; cmd_count = 16'(n);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    do begin @(negedge clk); #1; end while (cmd_ready !== 1'b1);
  endtask

  task automatic do_check(int op, logic [15:0] d, logic [7:0] a, int n);
    string tag;
    case (op)
      0, 1: tag = "R3"; 2: tag = "R4"; 3: tag = "R5"; 4: tag = "R6";
      5: tag = "R7"; 6: tag = "R4/R9"; default: tag = "R9";
    endcase
    build(op, d, a, n);
    run_op(op, d, a, n);
    chk({tag, " write strobe count"}, wn, ex_n);
    for (int i = 0; i < ex_n && i < wn; i++) begin
      chk({tag, " byte value"}, wl_val[i], ex_val[i]);
      chk("R3 command select", wl_cmd[i], ex_cmd[i]);
    end
    chk({tag, " read strobe count"}, rn, ex_rd);
    chk({tag, " response count"}, rspn, ex_has ? 1 : 0);
    if (ex_has) chk({tag, " response data"}, rsp_got, ex_rsp);
    chk("R8 chip select high cycles", cs_hi, ex_cs);
    chk("R12 driver on during read", oe_bad, 0);
    chk("R13 strobes overlap", both_low, 0);
    chk("R3 command select idle after op", disp_cmd_n, 1);
  endtask

  initial begin
    void'($urandom(32'h1234_5eed));
    for (int i = 0; i < 8; i++) feed[i] = 8'(i * 37 + 11);
    clear();
    repeat (3) @(negedge clk);
    chk("R1 write strobe idle", disp_wr_n, 1);
    chk("R1 read strobe idle", disp_rd_n, 1);
    chk("R1 command select idle", disp_cmd_n, 1);
    chk("R1 chip select idle", disp_cs_n, 1);
    chk("R1 driver enabled", disp_doe, 1);
    #1 rst_n = 1'b1;
    clear();
    @(negedge clk); #1;
    chk("R1 not ready during boot", cmd_ready, 0);
    chk("R2 not ready during boot", cmd_ready, 0);
    do begin @(negedge clk); #1; end while (cmd_ready !== 1'b1);
    chk("R10 boot reset low length", rlow, HOLD);
    chk("R10 boot post wait", rpost, POST);
    chk("R10 boot chip select forced", cs_bad, 0);
    chk("R10 boot pre wait in range", (rpre >= PRE - 4 && rpre <= PRE + 4) ? 1 : 0, 1);

    // R11: chip select follows enable
    @(negedge clk); bus_en = 1'b0; repeat (2) @(negedge clk);
    chk("R11 disabled select high", disp_cs_n, 1);
    bus_en = 1'b1; repeat (2) @(negedge clk);
    chk("R11 enabled select low", disp_cs_n, 0);

    // directed corners
    do_check(3, 16'h5A5A, 8'h00, 3);   // R5 equal bytes
    do_check(3, 16'h1234, 8'h00, 2);   // R5 unequal bytes
    do_check(3, 16'h7777, 8'h00, 0);   // R5 zero count
    do_check(0, 16'h002C, 8'h00, 0);
    feed[1] = 8'hFC; feed[2] = 8'h04; feed[3] = 8'h80;
    do_check(4, 16'h0, 8'h00, 0);      // R6 pad bits dropped
    do_check(5, 16'h0, 8'hD3, 0);      // R7 / R8
    do_check(7, 16'h0, 8'h22, 0);      // R9 no dummy

    // random mix
    for (int k = 0; k < 40; k++) begin
      int op;
      logic [15:0] d;
      op = int'($urandom_range(0, 7));
      d = 16'($urandom);
      if ($urandom_range(0, 3) == 0) d[7:0] = d[15:8];
      for (int i = 0; i < 8; i++) feed[i] = 8'($urandom);
      do_check(op, d, 8'($urandom), int'($urandom_range(0, 5)));
    end

    // explicit display reset
    run_op(8, 16'h0, 8'h00, 0);
    chk("R10 reset low length", rlow, HOLD);
    chk("R10 post wait", rpost, POST);
    chk("R10 chip select forced high", cs_bad, 0);
    chk("R10 no strobes", wn + rn, 0);
    summary();
  end
endmodule